// File: doc/BRIEF.md
# Tracking ADC Up/Down Controller

This block is the digital heart of a tracking analog-to-digital converter. An external DAC is driven by the block's code. The DAC output is summed with the analog input, and two window comparators watch the resulting node. One comparator reports that the node sits under the window and the other that it sits over it. On every sample-enable tick the controller reads both comparators and moves the code one count up, one count down, or leaves it alone. Because of this, the loop follows the input and the code sequence cannot skip values.

The code is both the DAC drive and the conversion result. It saturates at both ends of its range instead of wrapping. A configuration input swaps which comparator raises the code, so an inverting analog front end can be used. Two conditions are reported:
- A comparator pair that claims both sides at once is an illegal state. The code holds and a fault flag is raised.
- A run of consecutive in-window samples raises a lock flag.

Top module: `trk_adc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the code loads mid-scale (2^(CODE_W-1), 2048 by default), and `locked` and `err` clear, all visible after that edge.
- R2: At an edge where `sample_en` is 0, `dac_code`, `locked` and `err` keep their values, whatever the comparators show.
- R3: With `invert_dir`=0, a sample where only `cmp_low` is 1 raises the code by one, and a sample where only `cmp_high` is 1 lowers it by one.
- R4: With `invert_dir`=1, the roles swap: a sample where only `cmp_high` is 1 raises the code by one, and a sample where only `cmp_low` is 1 lowers it by one.
- R5: A sample with both comparator bits at 0 (inside the dead band) leaves the code unchanged.
- R6: The code saturates instead of wrapping. An upward request at 2^CODE_W-1 leaves it at 2^CODE_W-1, and a downward request at 0 leaves it at 0.
- R7: A sample with both comparator bits at 1 leaves the code unchanged and sets `err` after that edge. The next sample with a legal pair clears `err`.
- R8: Between any two consecutive clock cycles outside reset, the code changes by at most one count. As a result, the output is monotonic for a monotonic input.
- R9: `locked` rises after the LOCK_CNT-th consecutive in-window sample. Edges without `sample_en` do not break the run. Any step request (including one blocked by saturation) or any illegal sample clears `locked` and restarts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle update tick; comparators are read only when it is 1 |
| cmp_low | input | 1 | 1 when the summing node is under the lower reference |
| cmp_high | input | 1 | 1 when the summing node is over the upper reference |
| invert_dir | input | 1 | 0: `cmp_low` raises the code; 1: `cmp_high` raises the code |
| dac_code | output | CODE_W | DAC drive code and conversion result |
| locked | output | 1 | In-window run has reached LOCK_CNT samples |
| err | output | 1 | Most recent sample had both comparators asserted |

## Verification
The bench builds the controller with CODE_W=4 and LOCK_CNT=3. With these values a 16-code range can be swept completely, from saturation at the bottom to saturation at the top, for both settings of `invert_dir`. Every comparator and enable combination is interleaved with each step. Dead-band runs shorter than, equal to, and longer than the lock length are tried, with idle edges inside them. A behavioural model of the DAC summing node and the window then closes the loop around a ramping input, to confirm that the code follows the input without skipping or reversing.

// File: rtl/trk_adc_pkg.sv
package trk_adc_pkg;

    typedef enum logic [2:0] {
        STEP_SKIP  = 3'd0,
        STEP_HOLD  = 3'd1,
        STEP_UP    = 3'd2,
        STEP_DOWN  = 3'd3,
        STEP_FAULT = 3'd4
    } trk_step_e;

    typedef struct packed {
        logic locked;
        logic fault;
    } trk_status_t;

    // Classify one comparator reading into a step command.
    function automatic trk_step_e trk_classify(logic en, logic lo, logic hi, logic inv);
        logic raise;
        logic lower;
        raise = inv ? hi : lo;
        lower = inv ? lo : hi;
        if (!en)
            return STEP_SKIP;
        else if (lo && hi)
            return STEP_FAULT;
        else if (raise)
            return STEP_UP;
        else if (lower)
            return STEP_DOWN;
        else
            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/trk_step_decode.sv
module trk_step_decode
    import trk_adc_pkg::*;
(
    input  logic      sample_en,
    input  logic      cmp_low,
    input  logic      cmp_high,
    input  logic      invert_dir,
    output trk_step_e step
);

    always_comb begin
        step = trk_classify(sample_en, cmp_low, cmp_high, invert_dir);
    end

endmodule

// File: rtl/trk_code_reg.sv
module trk_code_reg
    import trk_adc_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  trk_step_e         step,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= CODE_MID;
        end else begin
            case (step)
                STEP_UP:   if (code != CODE_MAX) code <= code + CODE_ONE;
                STEP_DOWN: if (code != CODE_MIN) code <= code - CODE_ONE;
                default:   code <= code;
            endcase
        end
    end

endmodule

// File: rtl/trk_status.sv
module trk_status
    import trk_adc_pkg::*;
#(
    parameter int LOCK_CNT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  trk_step_e   step,
    output trk_status_t status
);

    localparam int CNT_W = $clog2(LOCK_CNT + 1);
    localparam logic [CNT_W-1:0] RUN_TOP  = CNT_W'(LOCK_CNT);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(LOCK_CNT - 1);
    localparam logic [CNT_W-1:0] RUN_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt       <= '0;
            status.locked <= 1'b0;
            status.fault  <= 1'b0;
        end else begin
            case (step)
                STEP_HOLD: begin
                    if (run_cnt != RUN_TOP) run_cnt <= run_cnt + RUN_ONE;
                    status.locked <= (run_cnt >= RUN_LAST);
                    status.fault  <= 1'b0;
                end
                STEP_UP, STEP_DOWN: begin
                    run_cnt       <= '0;
                    status.locked <= 1'b0;
                    status.fault  <= 1'b0;
                end
                STEP_FAULT: begin
                    run_cnt       <= '0;
                    status.locked <= 1'b0;
                    status.fault  <= 1'b1;
                end
                default: begin
                    run_cnt <= run_cnt;
                    status  <= status;
                end
            endcase
        end
    end

endmodule

// File: rtl/trk_adc_ctrl.sv
module trk_adc_ctrl
    import trk_adc_pkg::*;
#(
    parameter int CODE_W   = 12,
    parameter int LOCK_CNT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic              cmp_low,
    input  logic              cmp_high,
    input  logic              invert_dir,
    output logic [CODE_W-1:0] dac_code,
    output logic              locked,
    output logic              err
);

    trk_step_e   step;
    trk_status_t status;

    trk_step_decode u_decode (
        .sample_en (sample_en),
        .cmp_low   (cmp_low),
        .cmp_high  (cmp_high),
        .invert_dir(invert_dir),
        .step      (step)
    );

    trk_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk (clk),
        .rst (rst),
        .step(step),
        .code(dac_code)
    );

    trk_status #(.LOCK_CNT(LOCK_CNT)) u_status (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .status(status)
    );

    assign locked = status.locked;
    assign err    = status.fault;

endmodule

// File: rtl/trk_adc_ctrl_chk.sv
module trk_adc_ctrl_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_en,
    input logic              cmp_low,
    input logic              cmp_high,
    input logic              invert_dir,
    input logic [CODE_W-1:0] dac_code,
    input logic              locked,
    input logic              err
);

    localparam logic [CODE_W-1:0] C_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] C_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W:0]   X_ONE = (CODE_W + 1)'(1);

    logic up_only;
    logic dn_only;
    assign up_only = invert_dir ? (cmp_high && !cmp_low) : (cmp_low && !cmp_high);
    assign dn_only = invert_dir ? (cmp_low && !cmp_high) : (cmp_high && !cmp_low);

    AST_RESET_MID: assert property (@(posedge clk)
        rst |=> (dac_code == C_MID) && !locked && !err); // R1

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(dac_code) && $stable(locked) && $stable(err)); // R2

    AST_DEADBAND_HOLD: assert property (@(posedge clk) disable iff (rst)
        sample_en && !cmp_low && !cmp_high |=> $stable(dac_code)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        sample_en && up_only && (dac_code == C_MAX) |=> dac_code == C_MAX); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        sample_en && dn_only && (dac_code == '0) |=> dac_code == '0); // R6

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        sample_en && cmp_low && cmp_high |=> err && $stable(dac_code)); // R7

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (dac_code == $past(dac_code))
              || ({1'b0, dac_code} == {1'b0, $past(dac_code)} + X_ONE)
              || ({1'b0, $past(dac_code)} == {1'b0, dac_code} + X_ONE)); // R8

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
        sample_en && (cmp_low || cmp_high) |=> !locked); // R9

endmodule

bind trk_adc_ctrl trk_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .cmp_low   (cmp_low),
    .cmp_high  (cmp_high),
    .invert_dir(invert_dir),
    .dac_code  (dac_code),
    .locked    (locked),
    .err       (err)
);

// File: tb/trk_adc_ctrl_bench.sv
`timescale 1ns/1ps
module trk_adc_ctrl_bench;

    localparam int W    = 4;
    localparam int LK   = 3;
    localparam int MAXV = (1 << W) - 1;
    localparam int MIDV = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sample_en = 1'b0;
    logic         cmp_low = 1'b0;
    logic         cmp_high = 1'b0;
    logic         invert_dir = 1'b0;
    logic [W-1:0] dac_code;
    logic         locked;
    logic         err;

    always #10 clk = ~clk;   // 50 MHz

    trk_adc_ctrl #(.CODE_W(W), .LOCK_CNT(LK)) u_trk_adc_ctrl (
        .clk(clk), .rst(rst), .sample_en(sample_en), .cmp_low(cmp_low),
        .cmp_high(cmp_high), .invert_dir(invert_dir),
        .dac_code(dac_code), .locked(locked), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int m_code, m_cnt;
    bit m_locked, m_err;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; sample_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_code = MIDV; m_cnt = 0; m_locked = 0; m_err = 0;
        rst = 1'b0;
        chk("R1 reset code", int'(dac_code), MIDV);
        chk("R1 reset locked", int'(locked), 0);
        chk("R1 reset err", int'(err), 0);
    endtask

    // Drive one cycle at the falling edge, update the model at the rising edge, check at the next falling edge.
    task automatic apply(bit en, bit lo, bit hi);
        string tag;
        int old;
        bit up, dn;
        old = m_code;
        up = invert_dir ? hi : lo;
        dn = invert_dir ? lo : hi;
        if (!en) tag = "R2 idle";
        else if (lo && hi) tag = "R7 illegal";
        else if ((up && m_code == MAXV) || (dn && m_code == 0)) tag = "R6 saturate";
        else if (up || dn) tag = invert_dir ? "R4 inverted step" : "R3 step";
        else tag = "R5 dead band";
        sample_en = en; cmp_low = lo; cmp_high = hi;
        @(posedge clk);
        if (en) begin
            if (lo && hi) begin
                m_err = 1; m_cnt = 0; m_locked = 0;
            end else begin
                m_err = 0;
                if (up) begin
                    if (m_code < MAXV) m_code++;
                    m_cnt = 0; m_locked = 0;
                end else if (dn) begin
                    if (m_code > 0) m_code--;
                    m_cnt = 0; m_locked = 0;
                end else begin
                    if (m_cnt < LK) m_cnt++;
                    m_locked = (m_cnt >= LK);
                end
            end
        end
        @(negedge clk);
        sample_en = 1'b0;
        chk(tag, int'(dac_code), m_code);
        chk("R9 locked", int'(locked), int'(m_locked));
        chk("R7 err", int'(err), int'(m_err));
        chk("R8 single step", int'((int'(dac_code) - old) <= 1 && (int'(dac_code) - old) >= -1), 1);
    endtask

    task automatic combos();
        apply(0, 1, 0);
        apply(0, 0, 1);
        apply(0, 1, 1);
        apply(1, 1, 1);
        apply(1, 0, 0);
    endtask

    initial begin
        for (int inv = 0; inv < 2; inv++) begin
            invert_dir = inv[0];
            do_reset();
            // Ramp up through the top limit
            for (int i = 0; i < MAXV + 3; i++) begin
                combos();
                if (inv == 0) apply(1, 1, 0); else apply(1, 0, 1);
            end
            // Ramp down through the bottom limit
            for (int i = 0; i < MAXV + 3; i++) begin
                combos();
                if (inv == 0) apply(1, 0, 1); else apply(1, 1, 0);
            end
            // Lock runs of assorted lengths, with idle edges inside them
            for (int len = 0; len <= LK + 2; len++) begin
                for (int k = 0; k < len; k++) begin
                    apply(1, 0, 0);
                    apply(0, 1, 0);
                end
                apply(1, 0, 0);
                if (len % 2 == 0) apply(1, 1, 1); else apply(1, 1, 0);
            end
            // Closed loop against a ramping input through a model of the summing node
            do_reset();
            for (int t = 0; t < 4 * MAXV + 40; t++) begin
                int vin, node;
                bit lo, hi;
                vin = t;
                node = inv ? (vin - 4 * m_code) : (4 * m_code - vin);
                lo = node < -2;
                hi = node > 2;
                apply(1, lo, hi);
            end
            chk("R8 loop follows input to full scale", int'(dac_code), MAXV);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule